// File: doc/BRIEF.md
# MDIO Clause 45 Management Slave

This block is the serial management front end of a pluggable module. It listens to a management clock and a shared bidirectional data line, decodes Clause 45 frames and turns them into plain accesses on a synchronous register port. It keeps a 16-bit address pointer and supports four operations: set the pointer, write at the pointer, read at the pointer, and read at the pointer followed by an increment. The register file itself, non-volatile storage and sensor sampling sit outside the block. It only presents an address, data and one-cycle strobes.

Several modules can share one bus. Each module answers only when the frame's port field matches its five strap pins. The straps are read live, so a new strap value applies to the next frame without a reset. Only device 1 is served. While the module reset input is held, the block never drives the line, so a host reads all ones through the bus pull-up and its writes are lost. A frame that stalls part way through, or that carries a bad turnaround on a write, is thrown away without touching the pointer or the register port.

Both the management clock and the data line are resampled in the system clock domain. No flop is clocked by the management clock.

Top module: `mdioMgmtSlave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive ones are sampled, followed by the bits 0 then 0. After that come a 2-bit opcode, a 5-bit port field, a 5-bit device field, 2 turnaround bits and 16 data bits, each sent MSB first and sampled on a rising edge of MDC. A run of 31 ones followed by those bits starts no frame.
- R2: A frame is served only when its port field equals `portAddr`, and the pins are compared anew in every frame. Changing the pins between frames moves the block to the new address without a reset.
- R3: A frame whose device field is not 1 causes no strobe, no drive of the line and no change of the pointer.
- R4: Opcode 00 loads its 16-bit data field into the address pointer and produces no strobe.
- R5: Opcode 01 produces exactly one `regWrEn` pulse, one cycle long, carrying `regAddr` equal to the pointer and `regWrData` equal to the data field. A write or address frame is dropped unless its turnaround bits are 1 then 0.
- R6: Opcode 11 raises `regRdEn` for one cycle, with `regAddr` equal to the pointer, right after the last device bit is sampled. The register side presents `regRdData` in the cycle after the strobe. The pointer does not change.
- R7: In a served read the line is released for the first turnaround bit and driven 0 for the second. The 16 data bits follow MSB first, each updated after a rising edge of MDC. The line is released after the last data bit.
- R8: Opcode 10 returns the word at the pointer and then adds one to the pointer, wrapping from 16'hFFFF to 16'h0000.
- R9: While `modRst` is high, `mdioOe` stays low and no strobe is issued, so a read returns 16'hFFFF on the pulled-up line and a write has no effect. Out of system reset, `mdioOe`, `regWrEn` and `regRdEn` are low.
- R10: If MDC shows no rising edge for `IDLE_TIMEOUT` system cycles during a frame, the frame is dropped. No strobe is issued and the pointer keeps its value.
- R11: Frames sent back to back with no idle bits, at an MDC period of 26 system cycles (just under 4 MHz at 100 MHz), are all served.
- R12: `regWrEn` and `regRdEn` are never high in the same cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| modRst | input | 1 | Module held in reset; line floated, frames ignored |
| portAddr | input | 5 | Live strap value of the port address |
| mdcIn | input | 1 | Management clock from the host |
| mdioIn | input | 1 | Sensed level of the management data line |
| mdioOut | output | 1 | Value driven onto the data line |
| mdioOe | output | 1 | Output enable for the data line driver |
| regAddr | output | 16 | Register address (the pointer) |
| regWrData | output | 16 | Write data |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdEn | output | 1 | One-cycle read strobe |
| regRdData | input | 16 | Read data, valid the cycle after `regRdEn` |

## Verification
Every result follows a rising MDC edge that passes two synchroniser flops and an edge detector. The write strobe and the updated line value therefore appear about three system cycles after the edge. The read strobe comes at the last device bit, and the read word is captured two cycles after that. The bench holds each MDC phase for 13 system cycles and samples the line just before raising MDC, so each driven bit has had more than ten cycles to settle. It counts strobes from a monitor and compares them a few cycles after the last bit of each frame, when every strobe of that frame has landed. For truncated frames it waits well past the idle limit before checking.

// File: rtl/mdioPkg.sv
package mdioPkg;
  localparam int OP_W  = 2;
  localparam int PRT_W = 5;
  localparam int DEV_W = 5;
  localparam int HDR_W = OP_W + PRT_W + DEV_W;

  localparam logic [OP_W-1:0]  OP_ADDR  = 2'b00;
  localparam logic [OP_W-1:0]  OP_WRITE = 2'b01;
  localparam logic [OP_W-1:0]  OP_RDINC = 2'b10;
  localparam logic [OP_W-1:0]  OP_READ  = 2'b11;
  localparam logic [DEV_W-1:0] DEV_ID   = 5'd1;

  typedef enum logic [2:0] {
    sHunt,
    sStart,
    sHdr,
    sTa,
    sData
  } ctlState_e;

  typedef struct packed {
    logic hdrShift;
    logic dataShift;
    logic loadPtr;
    logic incPtr;
    logic wrCommit;
    logic rdIssue;
    logic drvRelease;
    logic drvZero;
    logic drvNext;
  } ctlStrobe_t;
endpackage

// File: rtl/mdioInSync.sv
module mdioInSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic mdcRaw,
  input  logic mdioRaw,
  output logic mdcRise,
  output logic mdioBit
);
  logic [STAGES-1:0] mdcSh;
  logic [STAGES-1:0] mdioSh;
  logic              mdcPrev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mdcSh  <= '0;
          mdioSh <= '1;
        end else begin
          mdcSh  <= mdcRaw;
          mdioSh <= mdioRaw;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          mdcSh  <= '0;
          mdioSh <= '1;
        end else begin
          mdcSh  <= {mdcSh[STAGES-2:0], mdcRaw};
          mdioSh <= {mdioSh[STAGES-2:0], mdioRaw};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mdcPrev <= 1'b0;
    else       mdcPrev <= mdcSh[STAGES-1];
  end

  assign mdcRise = mdcSh[STAGES-1] & ~mdcPrev;
  assign mdioBit = mdioSh[STAGES-1];
endmodule

// File: rtl/mdioCtrl.sv
module mdioCtrl
  import mdioPkg::*;
#(
  parameter int PREAMBLE_LEN = 32,
  parameter int IDLE_TIMEOUT = 1024,
  parameter int DATA_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modRst,
  input  logic             mdcRise,
  input  logic             mdioBit,
  input  logic [HDR_W-1:0] hdrWord,
  input  logic [PRT_W-1:0] portAddr,
  output ctlStrobe_t       stb
);
  localparam int PRE_W  = $clog2(PREAMBLE_LEN + 1);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int IDLE_W = $clog2(IDLE_TIMEOUT + 1);
  localparam logic [PRE_W-1:0]  PRE_FULL  = PRE_W'(PREAMBLE_LEN);
  localparam logic [CNT_W-1:0]  LAST_HDR  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0]  LAST_DATA = CNT_W'(DATA_W - 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM  = IDLE_W'(IDLE_TIMEOUT);

  ctlState_e         state, stateN;
  logic [PRE_W-1:0]  preCnt, preCntN;
  logic [CNT_W-1:0]  bitCnt, bitCntN;
  logic [IDLE_W-1:0] idleCnt;
  logic [OP_W-1:0]   opQ, opN;
  logic              match, matchN;
  logic              timedOut;

  logic [OP_W-1:0]  hdrOp;
  logic [PRT_W-1:0] hdrPrt;
  logic [DEV_W-1:0] hdrDev;

  assign hdrOp    = hdrWord[HDR_W-1 -: OP_W];
  assign hdrPrt   = hdrWord[DEV_W +: PRT_W];
  assign hdrDev   = hdrWord[DEV_W-1:0];
  assign timedOut = (idleCnt == IDLE_LIM);

  always_comb begin
    stateN  = state;
    preCntN = preCnt;
    bitCntN = bitCnt;
    opN     = opQ;
    matchN  = match;
    stb     = '0;
    if (modRst || timedOut) begin
      stateN         = sHunt;
      preCntN        = '0;
      stb.drvRelease = 1'b1;
    end else if (mdcRise) begin
      unique case (state)
        sHunt: begin
          if (mdioBit) begin
            if (preCnt != PRE_FULL) preCntN = preCnt + 1'b1;
          end else if (preCnt == PRE_FULL) begin
            stateN = sStart;
          end else begin
            preCntN = '0;
          end
        end
        sStart: begin
          if (!mdioBit) begin
            stateN  = sHdr;
            bitCntN = '0;
          end else begin
            stateN  = sHunt;
            preCntN = PRE_W'(1);
          end
        end
        sHdr: begin
          stb.hdrShift = 1'b1;
          if (bitCnt == LAST_HDR) begin
            stateN  = sTa;
            bitCntN = '0;
            opN     = hdrOp;
            matchN  = (hdrPrt == portAddr) && (hdrDev == DEV_ID);
            if (matchN && hdrOp[1]) stb.rdIssue = 1'b1;
          end else begin
            bitCntN = bitCnt + 1'b1;
          end
        end
        sTa: begin
          if (bitCnt == '0) begin
            if (!opQ[1] && !mdioBit) begin
              stateN  = sHunt;
              preCntN = '0;
            end else begin
              bitCntN = CNT_W'(1);
              if (opQ[1] && match) stb.drvZero = 1'b1;
            end
          end else begin
            if (!opQ[1] && mdioBit) begin
              stateN  = sHunt;
              preCntN = '0;
            end else begin
              stateN  = sData;
              bitCntN = '0;
              if (opQ[1] && match) stb.drvNext = 1'b1;
            end
          end
        end
        sData: begin
          stb.dataShift = !opQ[1];
          if (bitCnt == LAST_DATA) begin
            stateN         = sHunt;
            preCntN        = '0;
            stb.drvRelease = 1'b1;
            if (match) begin
              unique case (opQ)
                OP_ADDR:  stb.loadPtr  = 1'b1;
                OP_WRITE: stb.wrCommit = 1'b1;
                OP_RDINC: stb.incPtr   = 1'b1;
                default:  ;
              endcase
            end
          end else begin
            bitCntN = bitCnt + 1'b1;
            if (opQ[1] && match) stb.drvNext = 1'b1;
          end
        end
        default: begin
          stateN  = sHunt;
          preCntN = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= sHunt;
      preCnt <= '0;
      bitCnt <= '0;
      opQ    <= OP_ADDR;
      match  <= 1'b0;
    end else begin
      state  <= stateN;
      preCnt <= preCntN;
      bitCnt <= bitCntN;
      opQ    <= opN;
      match  <= matchN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          idleCnt <= '0;
    else if (state == sHunt || mdcRise) idleCnt <= '0;
    else if (!timedOut)                 idleCnt <= idleCnt + 1'b1;
  end
endmodule

// File: rtl/mdioDatapath.sv
module mdioDatapath
  import mdioPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mdioBit,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] regRdData,
  output logic [HDR_W-1:0]  hdrWord,
  output logic [DATA_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              mdioOut,
  output logic              mdioOe
);
  logic [HDR_W-2:0]  hdrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] ptrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] wordNext;
  logic              wrEnQ, rdEnQ, rdCapQ, outQ, oeQ;

  assign hdrWord  = {hdrQ, mdioBit};
  assign wordNext = {dataQ[DATA_W-2:0], mdioBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrQ    <= '0;
      dataQ   <= '0;
      ptrQ    <= '0;
      wrDataQ <= '0;
      wrEnQ   <= 1'b0;
      rdEnQ   <= 1'b0;
      rdCapQ  <= 1'b0;
      outQ    <= 1'b1;
      oeQ     <= 1'b0;
    end else begin
      wrEnQ  <= stb.wrCommit;
      rdEnQ  <= stb.rdIssue;
      rdCapQ <= rdEnQ;
      if (stb.hdrShift) hdrQ <= hdrWord[HDR_W-2:0];
      if (rdCapQ)             dataQ <= regRdData;
      else if (stb.dataShift) dataQ <= wordNext;
      else if (stb.drvNext)   dataQ <= {dataQ[DATA_W-2:0], 1'b0};
      if (stb.wrCommit) wrDataQ <= wordNext;
      if (stb.loadPtr)     ptrQ <= wordNext;
      else if (stb.incPtr) ptrQ <= ptrQ + 1'b1;
      if (stb.drvRelease) begin
        oeQ  <= 1'b0;
        outQ <= 1'b1;
      end else if (stb.drvZero) begin
        oeQ  <= 1'b1;
        outQ <= 1'b0;
      end else if (stb.drvNext) begin
        oeQ  <= 1'b1;
        outQ <= dataQ[DATA_W-1];
      end
    end
  end

  assign regAddr   = ptrQ;
  assign regWrData = wrDataQ;
  assign regWrEn   = wrEnQ;
  assign regRdEn   = rdEnQ;
  assign mdioOut   = outQ;
  assign mdioOe    = oeQ;
endmodule

// File: rtl/mdioMgmtSlave.sv
module mdioMgmtSlave
  import mdioPkg::*;
#(
  parameter int PREAMBLE_LEN = 32,
  parameter int IDLE_TIMEOUT = 1024,
  parameter int SYNC_STAGES  = 2,
  parameter int DATA_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modRst,
  input  logic [4:0]        portAddr,
  input  logic              mdcIn,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [DATA_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);
  logic             mdcRise;
  logic             mdioBit;
  logic [HDR_W-1:0] hdrWord;
  ctlStrobe_t       stb;

  mdioInSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .mdcRaw  (mdcIn),
    .mdioRaw (mdioIn),
    .mdcRise (mdcRise),
    .mdioBit (mdioBit)
  );

  mdioCtrl #(
    .PREAMBLE_LEN (PREAMBLE_LEN),
    .IDLE_TIMEOUT (IDLE_TIMEOUT),
    .DATA_W       (DATA_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modRst   (modRst),
    .mdcRise  (mdcRise),
    .mdioBit  (mdioBit),
    .hdrWord  (hdrWord),
    .portAddr (portAddr),
    .stb      (stb)
  );

  mdioDatapath #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .mdioBit   (mdioBit),
    .stb       (stb),
    .regRdData (regRdData),
    .hdrWord   (hdrWord),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe)
  );
endmodule

// File: rtl/mdioSlaveChk.sv
module mdioSlaveChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              modRst,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic              mdioOe,
  input logic              mdioOut,
  input logic [DATA_W-1:0] regAddr
);
  // R9
  held_reset_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    modRst |=> !mdioOe);

  // R9
  held_reset_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    modRst |=> !regWrEn);

  // R12
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));

  // R12
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R12
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> !regRdEn);

  // R7
  turnaround_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  // R6
  read_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> $stable(regAddr));
endmodule

bind mdioMgmtSlave mdioSlaveChk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .modRst  (modRst),
  .regWrEn (regWrEn),
  .regRdEn (regRdEn),
  .mdioOe  (mdioOe),
  .mdioOut (mdioOut),
  .regAddr (regAddr)
);

// File: tb/test_mdioMgmtSlave.sv
module test_mdioMgmtSlave;
  localparam int HALF  = 13;
  localparam int TMO   = 1024;
  localparam int NRAND = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modRst = 1'b0;
  logic [4:0]  portAddr = 5'd6;
  logic        mdc = 1'b0;
  logic        hostBit = 1'b1;
  logic        hostOe = 1'b1;
  logic        mdioOut, mdioOe, regWrEn, regRdEn;
  logic [15:0] regAddr, regWrData;
  logic [15:0] rdDataQ;
  wire         line = hostOe ? hostBit : (mdioOe ? mdioOut : 1'b1);

  always #5 clk = ~clk;

  mdioMgmtSlave #(.IDLE_TIMEOUT(TMO)) i_mdioMgmtSlave (
    .clk       (clk),
    .rstN      (rstN),
    .modRst    (modRst),
    .portAddr  (portAddr),
    .mdcIn     (mdc),
    .mdioIn    (line),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regRdData (rdDataQ)
  );

  // register file and strobe monitor
  logic [15:0] mem [64];
  int          wrCnt = 0, rdCnt = 0, oeCnt = 0, badStb = 0;
  logic [15:0] lastWrA = '0, lastWrD = '0;
  logic        prevWr = 1'b0, prevRd = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      rdDataQ <= '0;
    end else begin
      if (regWrEn) begin
        wrCnt <= wrCnt + 1;
        lastWrA <= regAddr;
        lastWrD <= regWrData;
        mem[regAddr[5:0]] <= regWrData;
      end
      if (regRdEn) begin
        rdCnt <= rdCnt + 1;
        rdDataQ <= mem[regAddr[5:0]];
      end
      if (mdioOe) oeCnt <= oeCnt + 1;
      if ((regWrEn && regRdEn) || (regWrEn && prevWr) || (regRdEn && prevRd))
        badStb <= badStb + 1;
      prevWr <= regWrEn;
      prevRd <= regRdEn;
    end
  end

  int          vecs = 0, errs = 0;
  logic [15:0] expMem [64];
  logic [15:0] expPtr = '0;

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitCyc(input logic b, input logic drive, output logic seen,
                        output logic oeAt);
    hostOe  = drive;
    hostBit = b;
    repeat (HALF) @(negedge clk);
    seen = line;
    oeAt = mdioOe;
    mdc  = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc  = 1'b0;
  endtask

  // sends a whole frame; nData < 16 leaves it truncated
  task automatic sendFrame(input int preLen, input logic [1:0] op, input logic [4:0] prt,
                           input logic [4:0] dev, input logic [15:0] data,
                           input logic [1:0] ta, input int nData,
                           output logic [15:0] rd, output logic ta1Oe,
                           output logic ta2Line);
    logic s, o;
    logic [11:0] hdr;
    hdr = {op, prt, dev};
    rd = '0; ta1Oe = 1'b0; ta2Line = 1'b1;
    for (int i = 0; i < preLen; i++) bitCyc(1'b1, 1'b1, s, o);
    bitCyc(1'b0, 1'b1, s, o);
    bitCyc(1'b0, 1'b1, s, o);
    for (int i = 11; i >= 0; i--) bitCyc(hdr[i], 1'b1, s, o);
    if (op[1]) begin
      bitCyc(1'b1, 1'b0, s, o); ta1Oe = o;
      bitCyc(1'b1, 1'b0, s, o); ta2Line = s;
      for (int i = 0; i < nData; i++) begin
        bitCyc(1'b1, 1'b0, s, o);
        rd = {rd[14:0], s};
      end
    end else begin
      bitCyc(ta[1], 1'b1, s, o);
      bitCyc(ta[0], 1'b1, s, o);
      for (int i = 15; i > 15 - nData; i--) bitCyc(data[i], 1'b1, s, o);
    end
    hostOe = 1'b1;
    hostBit = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic runFrame(input int preLen, input logic [1:0] op, input logic [4:0] prt,
                          input logic [4:0] dev, input logic [15:0] data,
                          input logic [1:0] ta, input string tag);
    int w0, r0, o0;
    bit acc;
    logic [15:0] rd;
    logic ta1Oe, ta2Line;
    w0 = wrCnt; r0 = rdCnt; o0 = oeCnt;
    acc = (preLen >= 32) && (prt == portAddr) && (dev == 5'd1) && !modRst &&
          (op[1] || ta == 2'b10);
    sendFrame(preLen, op, prt, dev, data, ta, 16, rd, ta1Oe, ta2Line);
    if (!acc) begin
      check(wrCnt == w0 && rdCnt == r0 && oeCnt == o0, {tag, " ignored frame"},
            16'(wrCnt - w0 + rdCnt - r0), 16'd0);
      if (op[1]) check(rd == 16'hFFFF, {tag, " floated read"}, rd, 16'hFFFF);
    end else begin
      case (op)
        2'b00: begin
          check(wrCnt == w0 && rdCnt == r0, {tag, " R4 address no strobe"},
                16'(wrCnt - w0), 16'd0);
          expPtr = data;
        end
        2'b01: begin
          check(wrCnt == w0 + 1 && lastWrA == expPtr, {tag, " R5 write addr"},
                lastWrA, expPtr);
          check(lastWrD == data, {tag, " R5 write data"}, lastWrD, data);
          expMem[expPtr[5:0]] = data;
        end
        default: begin
          check(rdCnt == r0 + 1 && rd == expMem[expPtr[5:0]], {tag, " R6 read data"},
                rd, expMem[expPtr[5:0]]);
          check(!ta1Oe && !ta2Line, {tag, " R7 turnaround"}, {14'd0, ta1Oe, ta2Line},
                16'd0);
          if (op == 2'b10) expPtr = expPtr + 16'd1;
        end
      endcase
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    vecs++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'd1, 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic t1, t2;
    int w0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) expMem[i] = '0;
    repeat (5) @(negedge clk);
    // R9 reset state
    check(!mdioOe && !regWrEn && !regRdEn, "R9 reset outputs",
          {13'd0, mdioOe, regWrEn, regRdEn}, 16'd0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R4/R5/R6/R11 back-to-back write then read
    runFrame(32, 2'b00, portAddr, 5'd1, 16'd10, 2'b10, "R4");
    runFrame(32, 2'b01, portAddr, 5'd1, 16'hBEEF, 2'b10, "R11 write");
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R11 read");
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R6 pointer kept");

    // R1 short preamble
    runFrame(31, 2'b01, portAddr, 5'd1, 16'h1111, 2'b10, "R1 short preamble");
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R1 after short");

    // R3 wrong device
    runFrame(32, 2'b01, portAddr, 5'd3, 16'h2222, 2'b10, "R3 device");
    runFrame(32, 2'b00, portAddr, 5'd0, 16'd20, 2'b10, "R3 device addr");
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R3 unchanged");

    // R5 bad turnaround
    runFrame(32, 2'b01, portAddr, 5'd1, 16'h3333, 2'b11, "R5 bad turnaround");
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R5 unchanged");

    // R2 port mismatch and live change
    runFrame(32, 2'b01, 5'd7, 5'd1, 16'h4444, 2'b10, "R2 mismatch");
    portAddr = 5'd21;
    runFrame(32, 2'b01, 5'd21, 5'd1, 16'h5555, 2'b10, "R2 new address");
    runFrame(32, 2'b01, 5'd6, 5'd1, 16'h6666, 2'b10, "R2 old address");
    runFrame(32, 2'b11, 5'd21, 5'd1, 16'h0, 2'b10, "R2 readback");

    // R8 wrap of the pointer
    runFrame(32, 2'b00, portAddr, 5'd1, 16'hFFFF, 2'b10, "R8 set");
    runFrame(32, 2'b01, portAddr, 5'd1, 16'hA5A5, 2'b10, "R8 write top");
    runFrame(32, 2'b10, portAddr, 5'd1, 16'h0, 2'b10, "R8 read inc");
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R8 wrapped");

    // R10 truncated write and address frames
    runFrame(32, 2'b00, portAddr, 5'd1, 16'd5, 2'b10, "R10 set");
    w0 = wrCnt;
    sendFrame(32, 2'b01, portAddr, 5'd1, 16'h7777, 2'b10, 8, rd, t1, t2);
    repeat (TMO + 200) @(negedge clk);
    check(wrCnt == w0, "R10 truncated write", 16'(wrCnt - w0), 16'd0);
    sendFrame(32, 2'b00, portAddr, 5'd1, 16'd40, 2'b10, 10, rd, t1, t2);
    repeat (TMO + 200) @(negedge clk);
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R10 pointer kept");

    // R9 module held in reset
    modRst = 1'b1;
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R9 read in reset");
    runFrame(32, 2'b01, portAddr, 5'd1, 16'h8888, 2'b10, "R9 write in reset");
    modRst = 1'b0;
    repeat (4) @(negedge clk);
    runFrame(32, 2'b11, portAddr, 5'd1, 16'h0, 2'b10, "R9 unchanged");

    // random mix, back to back (R11)
    for (int n = 0; n < NRAND; n++) begin
      logic [1:0] op;
      logic [4:0] prt, dev;
      logic [15:0] data;
      op   = 2'($urandom % 4);
      prt  = ($urandom % 8 == 0) ? 5'($urandom) : portAddr;
      dev  = ($urandom % 8 == 0) ? 5'($urandom) : 5'd1;
      data = (op == 2'b00) ? 16'($urandom % 64) : 16'($urandom);
      runFrame(32, op, prt, dev, data, 2'b10, "R11 random");
    end

    check(badStb == 0, "R12 strobe shape", 16'(badStb), 16'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule